// File: doc/BRIEF.md
# Privilege-Level Local Interrupt Router

This block picks the local interrupt that a hart should take next when it runs machine, hypervisor-supervisor (HS) and virtual-supervisor (VS) levels. It combines the raw pending and enable masks with a guest external pending bit, splits the result into three candidate sets using the two delegation masks, gates each set with an enable derived from the current privilege, the virtualisation flag and the two global interrupt-enable status bits, and arbitrates the first non-empty set by programmable 8-bit priorities.

Each level owns a 64-entry priority store with a fixed reset image. The stores are loaded through a plain write port (level select, index, data, write enable). The chosen interrupt number and a valid flag are registered once, so the answer appears one clock after the inputs that produced it. Decoding of control-register writes and the trap entry sequence live elsewhere.

Top module: `irq_router`

## Requirements
- R1: The effective pending vector is (irq_pend OR g) AND irq_en, where g has only bit 10 set, and only when guest_pend[guest_sel] is 1. With nothing to choose, irq_valid is 0 and irq_num is 0.
- R2: With virt_on = 1, the M and HS levels are always enabled. VS is enabled when priv is below S, or when priv is S and st_sie = 1. Privilege encoding: 0 = U, 1 = S, 3 = M.
- R3: With virt_on = 0, VS is disabled. M is enabled when priv is below M, or when priv is M and st_mie = 1. HS is enabled when priv is below S, or when priv is S and st_sie = 1.
- R4: M candidates are pending AND NOT mdeleg. HS candidates are pending AND mdeleg AND NOT hdeleg. VS candidates are pending AND mdeleg AND hdeleg. Each set is forced to zero when its level is disabled.
- R5: Levels are tried in the fixed order M, HS, VS. Only the first non-empty set is arbitrated, and all lower sets are ignored.
- R6: Within a level, the lowest effective priority wins, and equal values go to the higher interrupt number. A nonzero stored entry is used as it is. A zero entry becomes the level's external default rank if the source is the level's external source. Otherwise it becomes 1 if the source's default rank is below that external rank, and 255 if not. The M level uses external source 11 with rank 32. HS and VS use source 9 with rank 40.
- R7: Default ranks are as follows. Sources 48..63 and 24..31 take 8..31, in groups of six per step b = 0..3: (63-4b, 62-4b, 31-2b, 30-2b, 61-4b, 60-4b). Sources 32..47 and 16..23 take 64..87 by the same pattern, with 47 and 23 as the tops. Sources 11, 3 and 7 take 32, 33 and 34. Sources 9, 1 and 5 take 40, 41 and 42. Source 12 takes 48. Sources 10, 2 and 6 take 56, 57 and 58. Every other source takes 255.
- R8: The VS candidate set is shifted right by one bit and arbitrated against the VS store. The winning index plus one is reported, so VS bit 0 can never be chosen.
- R9: After reset, every M and HS entry holds its default rank, except that entry 11 (M) and entry 9 (HS) are 0. VS entries are 0, except that sources 1, 5, 13, 14, 15, 16, 18, 20, 22, 24, 26, 28 and 30 hold the M reset value.
- R10: A write with pw_en = 1 stores pw_data at pw_idx of level pw_level (0 = M, 1 = HS, 2 = VS, 3 = no write) on the clock edge. The next arbitration uses the new value.
- R11: Outputs are registered. They reflect the inputs present at the previous rising edge, and they are 0 during and right after a synchronous reset with rst_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | 64 | Raw pending bits |
| irq_en | input | 64 | Per-source enable bits |
| mdeleg | input | 64 | Delegation from M to HS |
| hdeleg | input | 64 | Delegation from HS to VS |
| guest_pend | input | GN | Guest external pending vector |
| guest_sel | input | log2(GN) | Selects the guest bit that feeds source 10 |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_on | input | 1 | Virtualisation active |
| st_mie | input | 1 | Machine global interrupt enable |
| st_sie | input | 1 | Supervisor global interrupt enable |
| pw_en | input | 1 | Priority write enable |
| pw_level | input | 2 | Target store (0 M, 1 HS, 2 VS) |
| pw_idx | input | 6 | Entry index |
| pw_data | input | 8 | Priority value |
| irq_valid | output | 1 | An interrupt is selected |
| irq_num | output | 6 | Selected interrupt number |

## Verification
The bench sweeps every pair of sources at each level with the reset priorities. A wrong default rank, a wrong zero-entry substitution or a wrong reset image shows up there as the wrong member of some pair winning, and a missed VS shift shows up as VS results off by one. It sweeps privilege, virtualisation and status combinations under random delegation. A level-order or enable mistake then reports an interrupt from a lower or disabled level. Further checks cover forced ties, where a design that favours the lower number fails, and the guest selector, where a wrong bit lets source 10 appear or vanish. Priority writes are each followed by arbitration in the very next cycle, and the output is sampled just before the clock edge to catch a missing or extra pipeline stage.

// File: rtl/irq_route_pkg.sv
// Package: shared constants and reset-image functions for the router.
// Assumes 64 local sources; ranks are computed, not tabulated.
package irq_route_pkg;
    localparam int RANK_HI   = 8;
    localparam int RANK_MLOC = 32;
    localparam int RANK_SLOC = 40;
    localparam int RANK_GEXT = 48;
    localparam int RANK_VLOC = 56;
    localparam int RANK_LO   = 64;
    localparam int RANK_MAX  = 255;
    localparam int EXT_SRC_M = 11;
    localparam int EXT_SRC_S = 9;
    localparam int GUEST_BIT = 10;

    // Position inside a 16+8 block: six sources per step.
    function automatic int block_pos(input int top_hi, input int top_lo, input int src);
        int j;
        int b;
        int r;
        if (src <= top_hi && src > top_hi - 16) begin
            j = top_hi - src;
            b = j / 4;
            r = j % 4;
            return 6 * b + ((r < 2) ? r : r + 2);
        end
        j = top_lo - src;
        b = j / 2;
        r = j % 2;
        return 6 * b + 2 + r;
    endfunction

    // Fixed default rank of a source.
    function automatic int default_rank(input int src);
        if (src >= 48 || (src >= 24 && src <= 31))
            return RANK_HI + block_pos(63, 31, src);
        if ((src >= 32 && src <= 47) || (src >= 16 && src <= 23))
            return RANK_LO + block_pos(47, 23, src);
        case (src)
            11: return RANK_MLOC;
            3:  return RANK_MLOC + 1;
            7:  return RANK_MLOC + 2;
            9:  return RANK_SLOC;
            1:  return RANK_SLOC + 1;
            5:  return RANK_SLOC + 2;
            12: return RANK_GEXT;
            10: return RANK_VLOC;
            2:  return RANK_VLOC + 1;
            6:  return RANK_VLOC + 2;
            default: return RANK_MAX;
        endcase
    endfunction

    // Sources whose VS entry starts from the M reset value.
    function automatic bit vs_copied(input int src);
        return src inside {1, 5, 13, 14, 15, 16, 18, 20, 22, 24, 26, 28, 30};
    endfunction

    // Reset value of an entry: level 0 M, 1 HS, 2 VS.
    function automatic int reset_value(input int level, input int src);
        if (level == 0) return (src == EXT_SRC_M) ? 0 : default_rank(src);
        if (level == 1) return (src == EXT_SRC_S) ? 0 : default_rank(src);
        if (vs_copied(src)) return (src == EXT_SRC_M) ? 0 : default_rank(src);
        return 0;
    endfunction
endpackage

// File: rtl/irq_prio_bank.sv
// Priority store for one level. Holds NSRC entries of PW bits, loaded with
// the level's reset image on a synchronous active-low reset, written one
// entry per cycle. Assumes widx < NSRC.
module irq_prio_bank
    import irq_route_pkg::*;
#(
    parameter int NSRC  = 64,
    parameter int PW    = 8,
    parameter int LEVEL = 0,
    localparam int IW   = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  logic [PW-1:0]            wdata,
    output logic [NSRC-1:0][PW-1:0]  prio_o
);
    logic [NSRC-1:0][PW-1:0] prio_q;

    // Reset image load or single-entry update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++)
                prio_q[i] <= PW'(reset_value(LEVEL, i));
        end else if (we) begin
            prio_q[widx] <= wdata;
        end
    end

    assign prio_o = prio_q;
endmodule

// File: rtl/irq_prio_arb.sv
// Priority arbiter for one level. Substitutes zero entries with an
// effective value from the level's external source and rank, then picks
// the minimum; ties favour the higher index. Purely combinational.
module irq_prio_arb
    import irq_route_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int PW       = 8,
    parameter int EXT_IDX  = 11,
    parameter int EXT_RANK = 32,
    localparam int IW      = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]          cand,
    input  logic [NSRC-1:0][PW-1:0]  prio,
    output logic                     valid,
    output logic [IW-1:0]            idx
);
    logic [NSRC-1:0][PW-1:0] eff;

    for (genvar g = 0; g < NSRC; g++) begin : g_eff
        localparam int ZVAL = (g == EXT_IDX) ? EXT_RANK :
                              ((default_rank(g) < EXT_RANK) ? 1 : RANK_MAX);
        // Effective priority of entry g.
        assign eff[g] = (prio[g] != '0) ? prio[g] : PW'(ZVAL);
    end

    // Minimum search, later (higher) index wins on equality.
    always_comb begin
        logic [PW:0] best;
        best  = '1;
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && ({1'b0, eff[i]} <= best)) begin
                best  = {1'b0, eff[i]};
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
// Privilege-level interrupt router top. Builds M/HS/VS candidate sets,
// arbitrates each with its own store, takes the first non-empty level in
// the order M, HS, VS and registers the result. Assumes GN is a power of 2.
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int PW   = 8,
    parameter int GN   = 8,
    localparam int IW  = $clog2(NSRC),
    localparam int GSW = $clog2(GN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_pend,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] mdeleg,
    input  logic [NSRC-1:0] hdeleg,
    input  logic [GN-1:0]   guest_pend,
    input  logic [GSW-1:0]  guest_sel,
    input  logic [1:0]      priv,
    input  logic            virt_on,
    input  logic            st_mie,
    input  logic            st_sie,
    input  logic            pw_en,
    input  logic [1:0]      pw_level,
    input  logic [IW-1:0]   pw_idx,
    input  logic [PW-1:0]   pw_data,
    output logic            irq_valid,
    output logic [IW-1:0]   irq_num
);
    localparam int NLVL = 3;

    logic [NSRC-1:0]         pend_eff;
    logic                    en_m, en_hs, en_vs;
    logic [NSRC-1:0]         cand_lv [NLVL];
    logic [NSRC-1:0][PW-1:0] prio_lv [NLVL];
    logic [NLVL-1:0]         arb_v;
    logic [IW-1:0]           arb_idx [NLVL];
    logic                    sel_v;
    logic [IW-1:0]           sel_n;

    // Effective pending: raw plus selected guest bit, masked by enables.
    always_comb begin
        pend_eff = irq_pend;
        pend_eff[GUEST_BIT] = irq_pend[GUEST_BIT] | guest_pend[guest_sel];
        pend_eff = pend_eff & irq_en;
    end

    // Per-level enables from privilege, virtualisation and status bits.
    always_comb begin
        if (virt_on) begin
            en_m  = 1'b1;
            en_hs = 1'b1;
            en_vs = (priv == 2'd0) || (priv == 2'd1 && st_sie);
        end else begin
            en_m  = (priv != 2'd3) || st_mie;
            en_hs = (priv == 2'd0) || (priv == 2'd1 && st_sie);
            en_vs = 1'b0;
        end
    end

    // Candidate sets; VS set pre-shifted down by one.
    always_comb begin
        cand_lv[0] = (pend_eff & ~mdeleg) & {NSRC{en_m}};
        cand_lv[1] = (pend_eff & mdeleg & ~hdeleg) & {NSRC{en_hs}};
        cand_lv[2] = ((pend_eff & mdeleg & hdeleg) & {NSRC{en_vs}}) >> 1;
    end

    for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
        localparam int EXT  = (lv == 0) ? EXT_SRC_M : EXT_SRC_S;
        localparam int ERNK = (lv == 0) ? RANK_MLOC : RANK_SLOC;

        irq_prio_bank #(.NSRC(NSRC), .PW(PW), .LEVEL(lv)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (pw_en && (pw_level == 2'(lv))),
            .widx   (pw_idx),
            .wdata  (pw_data),
            .prio_o (prio_lv[lv])
        );

        irq_prio_arb #(.NSRC(NSRC), .PW(PW), .EXT_IDX(EXT), .EXT_RANK(ERNK)) arb_i (
            .cand  (cand_lv[lv]),
            .prio  (prio_lv[lv]),
            .valid (arb_v[lv]),
            .idx   (arb_idx[lv])
        );
    end

    // Strict level order; VS index shifted back up.
    always_comb begin
        sel_v = |arb_v;
        sel_n = '0;
        if (arb_v[0])      sel_n = arb_idx[0];
        else if (arb_v[1]) sel_n = arb_idx[1];
        else if (arb_v[2]) sel_n = arb_idx[2] + IW'(1);
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_num   <= '0;
        end else begin
            irq_valid <= sel_v;
            irq_num   <= sel_n;
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
// Checker for irq_router: tracks last cycle's candidate sets from the
// ports and checks the registered choice against them.
module irq_router_chk #(
    parameter int NSRC = 64,
    parameter int PW   = 8,
    parameter int GN   = 8,
    localparam int IW  = $clog2(NSRC),
    localparam int GSW = $clog2(GN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_pend,
    input logic [NSRC-1:0] irq_en,
    input logic [NSRC-1:0] mdeleg,
    input logic [NSRC-1:0] hdeleg,
    input logic [GN-1:0]   guest_pend,
    input logic [GSW-1:0]  guest_sel,
    input logic [1:0]      priv,
    input logic            virt_on,
    input logic            st_mie,
    input logic            st_sie,
    input logic            pw_en,
    input logic [1:0]      pw_level,
    input logic [IW-1:0]   pw_idx,
    input logic [PW-1:0]   pw_data,
    input logic            irq_valid,
    input logic [IW-1:0]   irq_num
);
    logic [NSRC-1:0] pe, cm, ch, cv, cm_q, ch_q, cv_q;
    logic            em, eh, ev;

    // Candidate sets seen at the ports this cycle.
    always_comb begin
        pe = irq_pend;
        pe[10] = irq_pend[10] | guest_pend[guest_sel];
        pe = pe & irq_en;
        em = virt_on || priv != 2'd3 || st_mie;
        eh = virt_on || priv == 2'd0 || (priv == 2'd1 && st_sie);
        ev = virt_on && (priv == 2'd0 || (priv == 2'd1 && st_sie));
        cm = em ? (pe & ~mdeleg) : '0;
        ch = eh ? (pe & mdeleg & ~hdeleg) : '0;
        cv = ev ? (pe & mdeleg & hdeleg) : '0;
        cv[0] = 1'b0;
    end

    // Delay candidates to line up with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_q <= '0;
            ch_q <= '0;
            cv_q <= '0;
        end else begin
            cm_q <= cm;
            ch_q <= ch;
            cv_q <= cv;
        end
    end

    p_m_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_q != '0) |-> (irq_valid && cm_q[irq_num]));

    p_hs_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_q == '0 && ch_q != '0) |-> (irq_valid && ch_q[irq_num]));

    p_vs_third_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_q == '0 && ch_q == '0 && cv_q != '0) |-> (irq_valid && cv_q[irq_num] && irq_num != '0));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_q == '0 && ch_q == '0 && cv_q == '0) |-> !irq_valid);

    p_num_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_num == '0));
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .PW(PW), .GN(GN)) chk_i (.*);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_pend = '0, irq_en = '0, mdeleg = '0, hdeleg = '0;
    logic [7:0]  guest_pend = '0;
    logic [2:0]  guest_sel = '0;
    logic [1:0]  priv = 2'd3;
    logic        virt_on = 1'b0, st_mie = 1'b0, st_sie = 1'b0;
    logic        pw_en = 1'b0;
    logic [1:0]  pw_level = '0;
    logic [5:0]  pw_idx = '0;
    logic [7:0]  pw_data = '0;
    logic        irq_valid;
    logic [5:0]  irq_num;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int drank [64];
    int shadow [3][64];

    always #5 clk = ~clk;

    irq_router dut_i (.*);

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hang exp finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Default ranks (R7) built from the grouped order.
    function automatic void build_ranks();
        int pos;
        for (int s = 0; s < 64; s++) drank[s] = 255;
        pos = 0;
        for (int b = 0; b < 4; b++) begin
            drank[63-4*b] = 8 + pos;      drank[47-4*b] = 64 + pos;
            drank[62-4*b] = 9 + pos;      drank[46-4*b] = 65 + pos;
            drank[31-2*b] = 10 + pos;     drank[23-2*b] = 66 + pos;
            drank[30-2*b] = 11 + pos;     drank[22-2*b] = 67 + pos;
            drank[61-4*b] = 12 + pos;     drank[45-4*b] = 68 + pos;
            drank[60-4*b] = 13 + pos;     drank[44-4*b] = 69 + pos;
            pos += 6;
        end
        drank[11] = 32; drank[3] = 33; drank[7] = 34;
        drank[9] = 40;  drank[1] = 41; drank[5] = 42;
        drank[12] = 48;
        drank[10] = 56; drank[2] = 57; drank[6] = 58;
    endfunction

    // Reset image (R9).
    function automatic void reset_shadow();
        int vkeep [13] = '{1, 5, 13, 14, 15, 16, 18, 20, 22, 24, 26, 28, 30};
        for (int s = 0; s < 64; s++) begin
            shadow[0][s] = (s == 11) ? 0 : drank[s];
            shadow[1][s] = (s == 9) ? 0 : drank[s];
            shadow[2][s] = 0;
        end
        foreach (vkeep[k]) shadow[2][vkeep[k]] = shadow[0][vkeep[k]];
    endfunction

    function automatic int eff_of(int lvl, int s);
        int ext = (lvl == 0) ? 11 : 9;
        int er  = (lvl == 0) ? 32 : 40;
        if (shadow[lvl][s] != 0) return shadow[lvl][s];
        if (s == ext) return er;
        return (drank[s] < er) ? 1 : 255;
    endfunction

    // R6 arbitration of one level.
    function automatic void arb(int lvl, logic [63:0] c, output bit v, output int n);
        int best = 1000;
        v = 0;
        n = 0;
        for (int s = 0; s < 64; s++) begin
            if (c[s] && eff_of(lvl, s) <= best) begin
                best = eff_of(lvl, s);
                n = s;
                v = 1;
            end
        end
    endfunction

    // Expected choice from the current inputs (R1..R5, R8).
    function automatic void model(output bit v, output int n);
        logic [63:0] pe, cm, ch, cv;
        bit em, eh, ev;
        pe = irq_pend;
        if (guest_pend[guest_sel]) pe[10] = 1'b1;
        pe = pe & irq_en;
        if (virt_on) begin
            em = 1; eh = 1;
            ev = (priv == 0) || (priv == 1 && st_sie);
        end else begin
            em = (priv < 3) || st_mie;
            eh = (priv == 0) || (priv == 1 && st_sie);
            ev = 0;
        end
        cm = em ? (pe & ~mdeleg) : 64'd0;
        ch = eh ? (pe & mdeleg & ~hdeleg) : 64'd0;
        cv = ev ? (pe & mdeleg & hdeleg) : 64'd0;
        if (cm != 0) arb(0, cm, v, n);
        else if (ch != 0) arb(1, ch, v, n);
        else begin
            arb(2, cv >> 1, v, n);
            if (v) n = n + 1;
        end
    endfunction

    // Apply current inputs, wait one edge, compare at the falling edge.
    task automatic check_now(string req);
        bit ev;
        int en;
        model(ev, en);
        @(posedge clk);
        @(negedge clk);
        total++;
        if (irq_valid !== ev || (ev && irq_num !== 6'(en)) || (!ev && irq_num !== 6'd0)) begin
            bad++;
            $display("FAIL %s: got v=%0b n=%0d exp v=%0b n=%0d", req, irq_valid, irq_num, ev, en);
        end
    endtask

    task automatic prio_write(int lvl, int idx, int val);
        pw_en = 1'b1;
        pw_level = 2'(lvl);
        pw_idx = 6'(idx);
        pw_data = 8'(val);
        @(posedge clk);
        @(negedge clk);
        pw_en = 1'b0;
        if (lvl < 3) shadow[lvl][idx] = val;
    endtask

    task automatic level_setup(int lvl);
        irq_en = '1;
        guest_pend = '0;
        priv = 2'd0;
        virt_on = (lvl == 2);
        mdeleg = (lvl == 0) ? 64'd0 : '1;
        hdeleg = (lvl == 2) ? '1 : 64'd0;
    endtask

    task automatic random_sweep(string req, int n_per);
        int privs [3] = '{0, 1, 3};
        for (int p = 0; p < 3; p++)
            for (int vz = 0; vz < 2; vz++)
                for (int st = 0; st < 4; st++)
                    for (int k = 0; k < n_per; k++) begin
                        priv = 2'(privs[p]);
                        virt_on = vz[0];
                        st_mie = st[0];
                        st_sie = st[1];
                        irq_pend = {$urandom, $urandom} & {$urandom, $urandom};
                        irq_en = (k % 3 == 0) ? '1 : {$urandom, $urandom};
                        mdeleg = {$urandom, $urandom};
                        hdeleg = {$urandom, $urandom};
                        guest_pend = 8'($urandom);
                        guest_sel = 3'($urandom);
                        check_now(req);
                    end
    endtask

    initial begin
        bit ev;
        int en;
        build_ranks();
        reset_shadow();
        irq_pend = '1;
        irq_en = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs cleared while reset is held.
        total++;
        if (irq_valid !== 1'b0 || irq_num !== 6'd0) begin
            bad++;
            $display("FAIL R11 reset: got v=%0b n=%0d exp v=0 n=0", irq_valid, irq_num);
        end
        rst_n = 1'b1;
        irq_pend = '0;
        check_now("R1 R11 idle after reset");

        // R11: output unchanged before the next edge, updated after it.
        level_setup(0);
        irq_pend = 64'd1 << 7;
        #1;
        total++;
        if (irq_valid !== 1'b0) begin
            bad++;
            $display("FAIL R11 latency: got v=%0b exp v=0", irq_valid);
        end
        check_now("R11 one-cycle update");

        // R6 R7 R9: all pairs at each level with reset priorities.
        for (int lvl = 0; lvl < 3; lvl++) begin
            level_setup(lvl);
            for (int i = 0; i < 64; i++)
                for (int j = i + 1; j < 64; j++) begin
                    irq_pend = (64'd1 << i) | (64'd1 << j);
                    check_now(lvl == 2 ? "R8 R9 VS pair" : "R6 R7 R9 pair");
                end
        end

        // R1: guest selector feeds bit 10; enables mask it.
        level_setup(0);
        irq_pend = '0;
        for (int s = 0; s < 8; s++)
            for (int g = 0; g < 8; g++) begin
                guest_sel = 3'(s);
                guest_pend = 8'd1 << g;
                check_now("R1 guest select");
            end
        irq_pend = 64'd1 << 20;
        irq_en = ~(64'd1 << 20);
        check_now("R1 enable mask");

        // R8: VS bit 0 alone is never chosen.
        level_setup(2);
        irq_pend = 64'd1;
        check_now("R8 VS bit0 dropped");

        // R2 R3 R4 R5: privilege and delegation sweep.
        random_sweep("R2 R3 R4 R5 sweep", 12);

        // R10: writes seen by the next arbitration, including ties (R6).
        level_setup(0);
        prio_write(0, 5, 7);
        prio_write(0, 40, 7);
        irq_pend = (64'd1 << 5) | (64'd1 << 40);
        check_now("R6 R10 tie to higher number");
        prio_write(3, 40, 1);
        check_now("R10 level 3 writes nothing");
        prio_write(0, 40, 8);
        check_now("R10 new value next cycle");
        for (int k = 0; k < 120; k++) begin
            int r = $urandom % 4;
            prio_write(k % 3, 6'($urandom), (r == 0) ? 0 : (r == 1) ? 7 : 8'($urandom));
        end
        random_sweep("R6 R10 programmed", 10);

        model(ev, en);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule